// File: doc/BRIEF.md
# Four-Channel Prioritized DMA Sequencer

This block moves data for four channels over one shared memory bus and holds the CPU off the bus while it does so. Each channel has a source address, a destination address, a length and a control word. Together these are written in a single configuration strobe. The enable bit in the control word latches the working copies of the addresses and the length. A channel becomes pending either at once, for the immediate trigger, or when an external event of its selected kind arrives.

Once a request is seen, a short countdown runs. The block then waits for a cycle in which the CPU sits between bus accesses and does not hold the bus locked. At that point it raises the CPU stall, spends one idle cycle, and moves elements until no channel is pending. It finishes with a closing idle cycle. Each element is a read followed by a write, as a word or a halfword. After every element the lowest-numbered pending channel is chosen again. A channel that becomes pending with a lower index therefore cuts in between elements, and the interrupted channel resumes afterwards.

On completion a channel may disable itself, keep running in repeat mode, or reload its destination. It can also raise an interrupt pulse. The memory bus is a plain request/acknowledge handshake, and the bus does not model wait states.

Top module: `dma4_seq`

## Requirements
- R1: The trigger field is control bits [7:6]. Code 0 means immediate: the channel becomes pending when its enable bit rises. Codes 1 to 3 make a channel pending when `trig_evt` pulses with `trig_kind` equal to that code. A `trig_evt` with `trig_kind` 0 has no effect. A request that arrives while the block is idle and not counting down loads a delay of 3. With a free bus slot, `cpu_stall` then rises at the third clock edge after the edge that captured the request.
- R2: The stall never begins in a cycle where `cpu_idle_slot` is low or `cpu_bus_lock` is high. While either condition holds, the start waits one cycle at a time, and it begins on the first edge where both conditions are clear.
- R3: The first and the last cycle of every stalled interval carry no bus request.
- R4: A latched length of 0 moves 2^LEN_HI_W elements on channel 3 and 2^LEN_LO_W elements on channels 0 to 2. On channels 0 to 2, only the low LEN_LO_W bits of the length are kept.
- R5: Word elements (control bit 5 set) use addresses with bits [1:0] cleared. Halfword elements use addresses with bit 0 cleared. This applies to both source and destination.
- R6: The source mode is control bits [3:2] and the destination mode is control bits [1:0]. The codes are 0 increment, 1 decrement, 2 fixed and 3 increment-with-reload. The step is 4 for words and 2 for halfwords, and a source in mode 3 stays fixed. A halfword is read from `mem_rdata[15:0]` and written on `mem_wdata[15:0]`, with the upper half written as zero.
- R7: Between elements, a pending channel with a lower index runs all its elements first. The interrupted channel then resumes where it stopped.
- R8: A channel 0 to 2 whose trigger code is 3 moves exactly 4 word elements to a fixed destination, whatever its programmed length, width and destination mode.
- R9: On completion, a channel whose repeat bit (control bit 4) is clear, or whose trigger code is 0, clears its enable bit (control bit 9, visible on `chan_en`). Otherwise it stays enabled. In destination mode 3, its destination restarts from the programmed destination address.
- R10: If control bit 8 is set, a channel's completion drives a one-cycle pulse on `irq_pulse` bit n for channel n. With bit 8 clear, no pulse is raised.
- R11: A source below LOW_LIMIT is never read. Instead one idle cycle passes and the channel's last read value is written. For halfwords, destination bit 1 selects its upper half (1) or lower half (0). A halfword read stores the halfword in both halves.
- R12: `act_ch` shows the index of the channel while its element is on the bus, and all ones otherwise. Every bus request falls inside `cpu_stall`, and a request is held with a stable address until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write all four registers of channel `cfg_ch` |
| cfg_ch | input | 2 | Channel selected for the write |
| cfg_src | input | AW | Source address |
| cfg_dst | input | AW | Destination address |
| cfg_len | input | LEN_HI_W | Element count |
| cfg_ctl | input | 10 | Control word: [9] enable, [8] irq enable, [7:6] trigger, [5] word, [4] repeat, [3:2] source mode, [1:0] destination mode |
| trig_evt | input | 1 | Trigger event pulse |
| trig_kind | input | 2 | Trigger code carried by the event |
| cpu_idle_slot | input | 1 | CPU is between bus accesses |
| cpu_bus_lock | input | 1 | CPU holds the bus locked |
| cpu_stall | output | 1 | CPU is held off the bus |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Request is a write |
| mem_word | output | 1 | Request is a word (else halfword) |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the current request |
| chan_en | output | 4 | Enable bit of each channel |
| irq_pulse | output | 4 | Completion interrupt pulses |
| act_ch | output | 3 | Channel on the bus, all ones when none |

## Verification
The bench builds the block with LEN_LO_W = 3 and LEN_HI_W = 4, keeping AW at 28. With these values a zero length means 8 elements on the low channels and 16 on channel 3. Both maximum-count runs and a preempted 12-element channel-3 run then finish in a few hundred cycles. As a result, the full count, the channel-3 distinction and a mid-run cut-in by channel 0 can all be compared element by element against a queue of predicted writes.

// File: rtl/dma4_seq.sv
module dma4_seq #(
  parameter int AW = 28,
  parameter int LEN_LO_W = 14,
  parameter int LEN_HI_W = 16,
  parameter int unsigned LOW_LIMIT = 32'h0200_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_ch,
  input  logic [AW-1:0]       cfg_src,
  input  logic [AW-1:0]       cfg_dst,
  input  logic [LEN_HI_W-1:0] cfg_len,
  input  logic [9:0]          cfg_ctl,
  input  logic                trig_evt,
  input  logic [1:0]          trig_kind,
  input  logic                cpu_idle_slot,
  input  logic                cpu_bus_lock,
  output logic                cpu_stall,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_word,
  output logic [AW-1:0]       mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  input  logic                mem_ack,
  output logic [3:0]          chan_en,
  output logic [3:0]          irq_pulse,
  output logic [2:0]          act_ch
);
  localparam int RW = LEN_HI_W + 1;
  localparam logic [LEN_HI_W-1:0] LO_MASK = LEN_HI_W'((1 << LEN_LO_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SEL, S_RD, S_WR, S_POST} st_t;
  st_t st;

  logic [AW-1:0] src_r [4], dst_r [4], src_l [4], dst_l [4];
  logic [LEN_HI_W-1:0] len_l [4];
  logic [9:0] ctl_r [4];
  logic [RW-1:0] rem [4];
  logic [31:0] rv [4];
  logic [3:0] pend, run, hit;
  logic [1:0] cnt, cur, sel, ch, smode, dmode;
  logic imm, spec, word, low;
  logic [AW-1:0] amask, step, saddr, daddr, src_nx, dst_nx;
  logic [RW-1:0] first_cnt;

  always_comb begin
    sel = 2'd0;
    for (int i = 3; i >= 0; i--) if (pend[i]) sel = 2'(i);
  end

  always_comb
    for (int i = 0; i < 4; i++)
      hit[i] = trig_evt && trig_kind != 2'd0 && ctl_r[i][9] && ctl_r[i][7:6] == trig_kind;

  assign imm   = cfg_we && cfg_ctl[9] && !ctl_r[cfg_ch][9] && cfg_ctl[7:6] == 2'd0;
  assign ch    = (st == S_SEL) ? sel : cur;
  assign spec  = ctl_r[ch][7:6] == 2'd3 && ch != 2'd3;
  assign word  = ctl_r[ch][5] | spec;
  assign smode = ctl_r[ch][3:2];
  assign dmode = spec ? 2'd2 : ctl_r[ch][1:0];
  assign amask = word ? AW'(3) : AW'(1);
  assign step  = word ? AW'(4) : AW'(2);
  assign saddr = src_l[ch] & ~amask;
  assign daddr = dst_l[ch] & ~amask;
  assign low   = saddr < AW'(LOW_LIMIT);

  assign first_cnt = spec ? RW'(4) :
                     (len_l[ch] != '0) ? RW'(len_l[ch]) :
                     (ch == 2'd3) ? (RW'(1) << LEN_HI_W) : (RW'(1) << LEN_LO_W);

  always_comb begin
    case (smode)
      2'd0:    src_nx = saddr + step;
      2'd1:    src_nx = saddr - step;
      default: src_nx = saddr;
    endcase
    case (dmode)
      2'd1:    dst_nx = daddr - step;
      2'd2:    dst_nx = daddr;
      default: dst_nx = daddr + step;
    endcase
  end

  assign cpu_stall = st != S_IDLE;
  assign mem_req   = (st == S_RD && !low) || st == S_WR;
  assign mem_we    = st == S_WR;
  assign mem_word  = word;
  assign mem_addr  = (st == S_WR) ? daddr : saddr;
  assign mem_wdata = word ? rv[ch] : {16'h0, daddr[1] ? rv[ch][31:16] : rv[ch][15:0]};
  assign act_ch    = (st == S_RD || st == S_WR) ? {1'b0, cur} : 3'b111;

  always_comb for (int i = 0; i < 4; i++) chan_en[i] = ctl_r[i][9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= 2'd0;
      cur <= 2'd0;
      pend <= '0;
      run <= '0;
      irq_pulse <= '0;
      for (int i = 0; i < 4; i++) begin
        src_r[i] <= '0; dst_r[i] <= '0; src_l[i] <= '0; dst_l[i] <= '0;
        len_l[i] <= '0; ctl_r[i] <= '0; rem[i] <= '0; rv[i] <= '0;
      end
    end else begin
      irq_pulse <= '0;
      case (st)
        S_IDLE:
          if (cnt == 2'd1) begin
            if (cpu_idle_slot && !cpu_bus_lock) begin
              st <= S_PRE;
              cnt <= 2'd0;
            end
          end else if (cnt != 2'd0) cnt <= cnt - 2'd1;
        S_PRE: st <= S_SEL;
        S_SEL:
          if (|pend) begin
            cur <= sel;
            if (!run[sel]) begin
              rem[sel] <= first_cnt;
              run[sel] <= 1'b1;
            end
            st <= S_RD;
          end else st <= S_POST;
        S_RD:
          if (low) st <= S_WR;
          else if (mem_ack) begin
            rv[cur] <= word ? mem_rdata : {mem_rdata[15:0], mem_rdata[15:0]};
            st <= S_WR;
          end
        S_WR:
          if (mem_ack) begin
            src_l[cur] <= src_nx;
            dst_l[cur] <= dst_nx;
            rem[cur] <= rem[cur] - RW'(1);
            st <= S_SEL;
            if (rem[cur] == RW'(1)) begin
              pend[cur] <= 1'b0;
              run[cur] <= 1'b0;
              if (ctl_r[cur][8]) irq_pulse[cur] <= 1'b1;
              if (!ctl_r[cur][4] || ctl_r[cur][7:6] == 2'd0) ctl_r[cur][9] <= 1'b0;
              else if (dmode == 2'd3) dst_l[cur] <= dst_r[cur];
            end
          end
        S_POST: begin
          st <= S_IDLE;
          if (|pend || |hit || imm) cnt <= 2'd3;
        end
        default: st <= S_IDLE;
      endcase
      for (int i = 0; i < 4; i++) if (hit[i]) pend[i] <= 1'b1;
      if (cfg_we) begin
        src_r[cfg_ch] <= cfg_src;
        dst_r[cfg_ch] <= cfg_dst;
        ctl_r[cfg_ch] <= cfg_ctl;
        if (cfg_ctl[9] && !ctl_r[cfg_ch][9]) begin
          src_l[cfg_ch] <= cfg_src;
          dst_l[cfg_ch] <= cfg_dst;
          len_l[cfg_ch] <= (cfg_ch == 2'd3) ? cfg_len : (cfg_len & LO_MASK);
          run[cfg_ch] <= 1'b0;
          if (cfg_ctl[7:6] == 2'd0) pend[cfg_ch] <= 1'b1;
        end
      end
      if (st == S_IDLE && cnt == 2'd0 && (|hit || imm)) cnt <= 2'd3;
    end
  end
endmodule

// File: rtl/dma4_seq_chk.sv
module dma4_seq_chk #(
  parameter int AW = 28,
  parameter int unsigned LOW_LIMIT = 32'h0200_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_stall,
  input logic          cpu_idle_slot,
  input logic          cpu_bus_lock,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_word,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [3:0]    irq_pulse,
  input logic [2:0]    act_ch
);
  a_r2_start_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(cpu_idle_slot && !cpu_bus_lock));

  a_r3_lead_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> !mem_req);

  a_r3_tail_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> !$past(mem_req));

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_word |-> mem_addr[1:0] == 2'b00);

  a_r5_half_align: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_word |-> !mem_addr[0]);

  a_r11_no_low_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr >= AW'(LOW_LIMIT));

  a_r10_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  a_r12_req_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall && act_ch != 3'b111);

  a_r12_none_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |-> act_ch == 3'b111);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind dma4_seq dma4_seq_chk #(.AW(AW), .LOW_LIMIT(LOW_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_stall(cpu_stall), .cpu_idle_slot(cpu_idle_slot),
  .cpu_bus_lock(cpu_bus_lock), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .irq_pulse(irq_pulse), .act_ch(act_ch));

// File: tb/dma4_seq_tb_top.sv
module dma4_seq_tb_top;
  localparam int AW = 28;
  localparam int LO = 3;
  localparam int HI = 4;
  localparam int unsigned LOWL = 32'h0200_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [HI-1:0] cfg_len = '0;
  logic [9:0] cfg_ctl = '0;
  logic trig_evt = 1'b0;
  logic [1:0] trig_kind = '0;
  logic cpu_idle_slot = 1'b1, cpu_bus_lock = 1'b0;
  logic cpu_stall, mem_req, mem_we, mem_word, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] chan_en, irq_pulse;
  logic [2:0] act_ch;

  always #5 clk = ~clk;

  dma4_seq #(.AW(AW), .LEN_LO_W(LO), .LEN_HI_W(HI), .LOW_LIMIT(LOWL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_len(cfg_len), .cfg_ctl(cfg_ctl), .trig_evt(trig_evt),
    .trig_kind(trig_kind), .cpu_idle_slot(cpu_idle_slot), .cpu_bus_lock(cpu_bus_lock),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .chan_en(chan_en), .irq_pulse(irq_pulse), .act_ch(act_ch));

  typedef struct packed { logic [AW-1:0] a; logic [31:0] d; logic w; } item_t;
  item_t q [4][$];
  logic [1:0] wlog [$];
  logic [31:0] rvm [4];
  int irq_cnt [4];
  int vec = 0, bad = 0;
  bit over = 1'b0;
  string tag = "R12";

  function automatic logic [31:0] fw(input logic [AW-1:0] a);
    return {~a[15:0], a[15:0]};
  endfunction
  function automatic logic [15:0] fh(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h3C3C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_we && !mem_ack)
        mem_rdata <= mem_word ? fw(mem_addr) : {16'hDEAD, fh(mem_addr)};
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we && mem_ack) begin
        if (act_ch == 3'b111) chk(1'b0, "R12", "act_ch during write", 32'(act_ch), 32'h0);
        else begin
          item_t it;
          logic [1:0] c;
          c = act_ch[1:0];
          wlog.push_back(c);
          if (q[c].size() == 0) chk(1'b0, tag, "unexpected write addr", 32'(mem_addr), 32'h0);
          else begin
            it = q[c].pop_front();
            chk(mem_addr == it.a, tag, "write addr", 32'(mem_addr), 32'(it.a));
            chk(mem_wdata == it.d, tag, "write data", mem_wdata, it.d);
            chk(mem_word == it.w, tag, "write width", 32'(mem_word), 32'(it.w));
          end
        end
      end
      if (mem_req && !mem_we && mem_ack && mem_addr < AW'(LOWL))
        chk(1'b0, "R11", "read below limit", 32'(mem_addr), 32'(LOWL));
      for (int i = 0; i < 4; i++) if (irq_pulse[i]) irq_cnt[i]++;
    end
  end

  function automatic logic [9:0] ctl(input bit en, input bit ie, input logic [1:0] trg,
      input bit w, input bit rpt, input logic [1:0] sm, input logic [1:0] dm);
    return {en, ie, trg, w, rpt, sm, dm};
  endfunction

  task automatic expect_run(input int c, input logic [AW-1:0] s0, input logic [AW-1:0] d0,
      input int n, input bit w, input logic [1:0] sm, input logic [1:0] dm);
    logic [AW-1:0] s, d, stp;
    logic [31:0] v, dat;
    stp = w ? AW'(4) : AW'(2);
    s = s0 & ~(w ? AW'(3) : AW'(1));
    d = d0 & ~(w ? AW'(3) : AW'(1));
    for (int k = 0; k < n; k++) begin
      if (s < AW'(LOWL)) v = rvm[c];
      else begin
        v = w ? fw(s) : {fh(s), fh(s)};
        rvm[c] = v;
      end
      dat = w ? v : {16'h0, d[1] ? v[31:16] : v[15:0]};
      q[c].push_back('{a: d, d: dat, w: w});
      if (sm == 2'd0) s = s + stp; else if (sm == 2'd1) s = s - stp;
      if (dm == 2'd1) d = d - stp; else if (dm != 2'd2) d = d + stp;
    end
  endtask

  task automatic prog(input int c, input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [HI-1:0] n, input logic [9:0] cw);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(c); cfg_src = s; cfg_dst = d; cfg_len = n;
    cfg_ctl = cw & 10'h1FF;
    @(negedge clk);
    cfg_ctl = cw;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [1:0] k);
    @(negedge clk);
    trig_evt = 1'b1; trig_kind = k;
    @(negedge clk);
    trig_evt = 1'b0;
  endtask

  task automatic wait_session();
    while (!cpu_stall) @(negedge clk);
    while (cpu_stall) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drained(input int c, input string req);
    chk(q[c].size() == 0, req, "pending expected writes", 32'(q[c].size()), 32'h0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int k, p, n3;
    bit prev;
    for (int i = 0; i < 4; i++) begin rvm[i] = '0; irq_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    chk(cpu_stall == 1'b0, "R12", "stall after reset", 32'(cpu_stall), 32'h0);
    chk(mem_req == 1'b0, "R12", "req after reset", 32'(mem_req), 32'h0);
    chk(act_ch == 3'b111, "R12", "act_ch after reset", 32'(act_ch), 32'h7);
    chk(chan_en == 4'h0, "R9", "enables after reset", 32'(chan_en), 32'h0);

    // R1: event trigger, word increment, start delay of 3
    tag = "R6";
    expect_run(1, 28'h300_0010, 28'h600_0000, 3, 1'b1, 2'd0, 2'd0);
    prog(1, 28'h300_0010, 28'h600_0000, 4'd3, ctl(1, 1, 2'd1, 1, 0, 2'd0, 2'd0));
    fire(2'd0);
    repeat (4) @(negedge clk);
    chk(cpu_stall == 1'b0, "R1", "trigger kind 0 ignored", 32'(cpu_stall), 32'h0);
    @(negedge clk);
    trig_evt = 1'b1; trig_kind = 2'd1;
    @(negedge clk);
    trig_evt = 1'b0;
    k = 1;
    while (!cpu_stall && k < 20) begin @(negedge clk); k++; end
    chk(k == 4, "R1", "negedges until stall", 32'(k), 32'd4);
    wait_session();
    drained(1, "R6");
    chk(chan_en[1] == 1'b0, "R9", "non-repeat disables", 32'(chan_en[1]), 32'h0);
    chk(irq_cnt[1] == 1, "R10", "irq count ch1", 32'(irq_cnt[1]), 32'd1);

    // R2: bus lock delays the start; halfword dec source, fixed destination
    tag = "R6";
    expect_run(2, 28'h300_0100, 28'h700_0000, 2, 1'b0, 2'd1, 2'd2);
    prog(2, 28'h300_0100, 28'h700_0000, 4'd2, ctl(1, 0, 2'd2, 0, 0, 2'd1, 2'd2));
    cpu_bus_lock = 1'b1;
    fire(2'd2);
    repeat (8) @(negedge clk);
    chk(cpu_stall == 1'b0, "R2", "stall while locked", 32'(cpu_stall), 32'h0);
    cpu_bus_lock = 1'b0;
    @(negedge clk);
    chk(cpu_stall == 1'b1, "R2", "stall after unlock", 32'(cpu_stall), 32'h1);
    wait_session();
    drained(2, "R6");
    chk(irq_cnt[2] == 0, "R10", "no irq when disabled", 32'(irq_cnt[2]), 32'h0);

    // R3: idle cycles at both ends; R2 with no free slot
    tag = "R3";
    expect_run(1, 28'h300_0200, 28'h600_0100, 1, 1'b1, 2'd0, 2'd0);
    prog(1, 28'h300_0200, 28'h600_0100, 4'd1, ctl(1, 0, 2'd1, 1, 0, 2'd0, 2'd0));
    cpu_idle_slot = 1'b0;
    fire(2'd1);
    repeat (6) @(negedge clk);
    chk(cpu_stall == 1'b0, "R2", "stall without slot", 32'(cpu_stall), 32'h0);
    cpu_idle_slot = 1'b1;
    while (!cpu_stall) @(negedge clk);
    chk(mem_req == 1'b0, "R3", "req in first stall cycle", 32'(mem_req), 32'h0);
    prev = 1'b0;
    while (cpu_stall) begin prev = mem_req; @(negedge clk); end
    chk(prev == 1'b0, "R3", "req in last stall cycle", 32'(prev), 32'h0);
    drained(1, "R3");

    // R4: zero length on channel 2 and channel 3 (channel 2 length 8 masks to 0)
    tag = "R4";
    wlog.delete();
    expect_run(2, 28'h400_0000, 28'h600_0200, 8, 1'b0, 2'd0, 2'd0);
    expect_run(3, 28'h400_1000, 28'h600_1000, 16, 1'b1, 2'd0, 2'd0);
    prog(2, 28'h400_0000, 28'h600_0200, 4'd8, ctl(1, 0, 2'd1, 0, 0, 2'd0, 2'd0));
    prog(3, 28'h400_1000, 28'h600_1000, 4'd0, ctl(1, 0, 2'd1, 1, 0, 2'd0, 2'd0));
    fire(2'd1);
    wait_session();
    n3 = 0; p = 0;
    foreach (wlog[i]) begin if (wlog[i] == 2'd3) n3++; if (wlog[i] == 2'd2) p++; end
    chk(p == 8, "R4", "ch2 element count", 32'(p), 32'd8);
    chk(n3 == 16, "R4", "ch3 element count", 32'(n3), 32'd16);
    drained(2, "R4");
    drained(3, "R4");

    // R5: misaligned addresses, word and halfword, immediate trigger
    tag = "R5";
    expect_run(0, 28'h300_0303, 28'h600_2002, 2, 1'b1, 2'd0, 2'd0);
    prog(0, 28'h300_0303, 28'h600_2002, 4'd2, ctl(1, 0, 2'd0, 1, 0, 2'd0, 2'd0));
    wait_session();
    drained(0, "R5");
    chk(chan_en[0] == 1'b0, "R9", "immediate disables", 32'(chan_en[0]), 32'h0);
    expect_run(1, 28'h300_0401, 28'h600_2101, 2, 1'b0, 2'd0, 2'd0);
    prog(1, 28'h300_0401, 28'h600_2101, 4'd2, ctl(1, 0, 2'd0, 0, 0, 2'd0, 2'd0));
    wait_session();
    drained(1, "R5");

    // R6/R9: repeat with destination reload on channel 3
    tag = "R9";
    expect_run(3, 28'h300_0600, 28'h600_3000, 3, 1'b0, 2'd1, 2'd3);
    prog(3, 28'h300_0600, 28'h600_3000, 4'd3, ctl(1, 1, 2'd1, 0, 1, 2'd1, 2'd3));
    fire(2'd1);
    wait_session();
    drained(3, "R9");
    chk(chan_en[3] == 1'b1, "R9", "repeat stays enabled", 32'(chan_en[3]), 32'h1);
    expect_run(3, 28'h300_05FA, 28'h600_3000, 3, 1'b0, 2'd1, 2'd3);
    fire(2'd1);
    wait_session();
    drained(3, "R9");
    chk(irq_cnt[3] == 2, "R10", "irq count ch3", 32'(irq_cnt[3]), 32'd2);

    // R6: source mode 3 behaves as fixed
    tag = "R6";
    expect_run(2, 28'h300_0700, 28'h600_4000, 2, 1'b0, 2'd3, 2'd0);
    prog(2, 28'h300_0700, 28'h600_4000, 4'd2, ctl(1, 0, 2'd2, 0, 0, 2'd3, 2'd0));
    fire(2'd2);
    wait_session();
    drained(2, "R6");

    // R9: repeat set with immediate trigger still disables
    tag = "R9";
    expect_run(1, 28'h300_0800, 28'h600_5000, 1, 1'b1, 2'd0, 2'd0);
    prog(1, 28'h300_0800, 28'h600_5000, 4'd1, ctl(1, 0, 2'd0, 1, 1, 2'd0, 2'd0));
    wait_session();
    drained(1, "R9");
    chk(chan_en[1] == 1'b0, "R9", "repeat+immediate disables", 32'(chan_en[1]), 32'h0);

    // R8: special trigger forces 4 words, fixed destination
    tag = "R8";
    expect_run(1, 28'h300_0900, 28'h600_6000, 4, 1'b1, 2'd0, 2'd2);
    prog(1, 28'h300_0900, 28'h600_6000, 4'd7, ctl(1, 0, 2'd3, 0, 0, 2'd0, 2'd0));
    fire(2'd3);
    wait_session();
    drained(1, "R8");

    // R7: channel 0 cuts into a running channel 3
    tag = "R7";
    wlog.delete();
    prog(3, 28'h300_0A00, 28'h600_7000, 4'd12, ctl(0, 0, 2'd1, 0, 0, 2'd0, 2'd0));
    expect_run(3, 28'h300_0A00, 28'h600_7000, 12, 1'b0, 2'd0, 2'd0);
    expect_run(0, 28'h300_0B00, 28'h600_8000, 2, 1'b1, 2'd0, 2'd0);
    prog(3, 28'h300_0A00, 28'h600_7000, 4'd12, ctl(1, 0, 2'd1, 0, 0, 2'd0, 2'd0));
    prog(0, 28'h300_0B00, 28'h600_8000, 4'd2, ctl(1, 0, 2'd2, 1, 0, 2'd0, 2'd0));
    fire(2'd1);
    while (wlog.size() < 3) @(negedge clk);
    fire(2'd2);
    wait_session();
    p = -1;
    foreach (wlog[i]) if (p < 0 && wlog[i] == 2'd0) p = i;
    chk(p >= 3, "R7", "ch0 first write position", 32'(p), 32'd3);
    chk(p >= 0 && p + 2 < wlog.size() && wlog[p + 1] == 2'd0 && wlog[p + 2] == 2'd3,
        "R7", "ch3 resumes after ch0", 32'(p), 32'(wlog.size()));
    chk(wlog.size() == 14, "R7", "total writes", 32'(wlog.size()), 32'd14);
    drained(0, "R7");
    drained(3, "R7");

    // R11: source below limit writes the last read value
    tag = "R11";
    expect_run(0, 28'h300_0C00, 28'h600_9000, 1, 1'b1, 2'd0, 2'd0);
    prog(0, 28'h300_0C00, 28'h600_9000, 4'd1, ctl(1, 0, 2'd0, 1, 0, 2'd0, 2'd0));
    wait_session();
    expect_run(0, 28'h000_0100, 28'h600_9002, 2, 1'b0, 2'd0, 2'd0);
    prog(0, 28'h000_0100, 28'h600_9002, 4'd2, ctl(1, 0, 2'd0, 0, 0, 2'd0, 2'd0));
    wait_session();
    expect_run(0, 28'h000_0200, 28'h600_9100, 1, 1'b1, 2'd0, 2'd0);
    prog(0, 28'h000_0200, 28'h600_9100, 4'd1, ctl(1, 0, 2'd0, 1, 0, 2'd0, 2'd0));
    wait_session();
    drained(0, "R11");
    chk(irq_cnt[0] == 0, "R10", "no irq ch0", 32'(irq_cnt[0]), 32'h0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule